// File: doc/BRIEF.md
# Page-Split DMA Descriptor Chain Builder

The block turns one transfer request (a start address, a byte length and a direction bit) into a chain of DMA command descriptors. It hands them out one at a time over a valid/ready port. The buffer is cut on fixed page boundaries. Only the first chunk can be shorter than a page: it is cut at the end of the page the start address lies in. Every later chunk is a full page, except the final data chunk. The address is taken as already physical.

Each descriptor carries a command code, a byte count, an address and three control fields (interrupt, wait, branch). Data descriptors use a "more" command, except the final one, which uses a "last" command. The command family (inbound or outbound) follows the direction bit. A stop descriptor always closes the chain, and a one-cycle done pulse marks the moment that stop descriptor is taken. A new request is accepted only while no chain is in progress.

Top module: `dchain_top`

## Requirements
- R1: `reqReady` is high only while no chain is in progress (`descValid` low). A request presented while a chain is in progress is not taken and does not change the chain being emitted.
- R2: If the start address is not page aligned and the length is larger than the bytes left in that page, the first descriptor has the start address, a count equal to `PAGE_BYTES` minus the page offset, and a "more" command.
- R3: After the first chunk, a full-page "more" descriptor is emitted while the remaining length is strictly greater than `PAGE_BYTES`. Each descriptor's address equals the previous address plus the previous count.
- R4: The final data descriptor carries all remaining bytes, between 1 and `PAGE_BYTES`, with a "last" command. A page-aligned request of exactly one page gives a single "last" descriptor.
- R5: An unaligned request that ends at or before the end of its first page gives a single "last" descriptor covering the whole length.
- R6: Command codes are 3 bits. Out-more is 0, out-last is 1, in-more is 2, in-last is 3 and stop is 7. `reqRead`=1 selects the in codes and `reqRead`=0 selects the out codes.
- R7: A stop descriptor (code 7) with count 0 and address 0 always follows the "last" descriptor.
- R8: Interrupt, wait and branch fields are 2'b00 ("never") in every descriptor, the stop descriptor included.
- R9: While `descValid` is high and `descReady` is low, the command, count and address stay unchanged.
- R10: A zero-length request gives one "last" descriptor with count 0 at the start address, followed by the stop descriptor.
- R11: `chainDone` is high for exactly the cycle in which the stop descriptor is accepted. `reqReady` is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Transfer request present |
| reqReady | output | 1 | Block idle, request taken when valid |
| reqAddr | input | ADDR_W | Physical start address |
| reqLen | input | LEN_W | Byte length |
| reqRead | input | 1 | 1 = inbound (read), 0 = outbound (write) |
| descValid | output | 1 | Descriptor on the output is valid |
| descReady | input | 1 | Consumer takes the descriptor |
| descCmd | output | 3 | Command code |
| descCount | output | LEN_W | Byte count |
| descAddr | output | ADDR_W | Physical address |
| descIntr | output | 2 | Interrupt control (always never) |
| descWait | output | 2 | Wait control (always never) |
| descBranch | output | 2 | Branch control (always never) |
| chainDone | output | 1 | Pulse as the stop descriptor is accepted |

## Verification
The bench builds the block with a 64-byte page and 16-bit address and length fields. With these values a chain of four or five descriptors already covers an unaligned head, full middle pages and a short tail. This keeps every chain short enough to check descriptor by descriptor. The page size also puts the corner cases within easy reach: a buffer ending exactly on its first page boundary, an exact single aligned page, and zero length. These run together with stalled ready and with requests presented while a chain is in progress.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
  typedef enum logic [2:0] {
    CMD_OUT_MORE = 3'd0,
    CMD_OUT_LAST = 3'd1,
    CMD_IN_MORE  = 3'd2,
    CMD_IN_LAST  = 3'd3,
    CMD_STOP     = 3'd7
  } descCmd_e;

  localparam logic [1:0] CTL_NEVER = 2'b00;

  typedef struct packed {
    logic load;
    logic advance;
    logic stopSel;
  } dpStrobe_t;
endpackage

// File: rtl/dchain_ctrl.sv
module dchain_ctrl
  import dchain_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      descReady,
  input  logic      isLast,
  output dpStrobe_t strobe,
  output logic      reqReady,
  output logic      descValid,
  output logic      chainDone
);
  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_STOP} state_e;
  state_e state, nextState;

  always_comb begin
    strobe    = '0;
    reqReady  = 1'b0;
    descValid = 1'b0;
    chainDone = 1'b0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.load = 1'b1;
          nextState   = ST_DATA;
        end
      end
      ST_DATA: begin
        descValid = 1'b1;
        if (descReady) begin
          strobe.advance = 1'b1;
          if (isLast) nextState = ST_STOP;
        end
      end
      ST_STOP: begin
        descValid      = 1'b1;
        strobe.stopSel = 1'b1;
        if (descReady) begin
          chainDone = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // R7: accepted final data descriptor is always followed by the stop descriptor
  assert_stop_follows_R7: assert property (@(posedge clk) disable iff (!rstN)
    (descValid && descReady && !strobe.stopSel && isLast) |=> (descValid && strobe.stopSel));

  // R11: done is a single-cycle pulse and the block is idle right after
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    chainDone |=> (!chainDone && reqReady));
endmodule

// File: rtl/dchain_dp.sv
module dchain_dp
  import dchain_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 24,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqRead,
  output logic              isLast,
  output logic [2:0]        descCmd,
  output logic [LEN_W-1:0]  descCount,
  output logic [ADDR_W-1:0] descAddr
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam logic [LEN_W-1:0] PAGE_LEN = LEN_W'(PAGE_BYTES);

  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  remLen;
  logic              dirRead;
  logic [LEN_W-1:0]  toBoundary;
  logic [LEN_W-1:0]  chunk;

  // bytes left up to the next page boundary; a full page when aligned
  always_comb begin
    toBoundary = PAGE_LEN - LEN_W'(curAddr[PAGE_W-1:0]);
    isLast     = (remLen <= toBoundary);
    chunk      = isLast ? remLen : toBoundary;
  end

  always_comb begin
    if (strobe.stopSel) begin
      descCmd   = CMD_STOP;
      descCount = '0;
      descAddr  = '0;
    end else begin
      if (dirRead) descCmd = isLast ? CMD_IN_LAST  : CMD_IN_MORE;
      else         descCmd = isLast ? CMD_OUT_LAST : CMD_OUT_MORE;
      descCount = chunk;
      descAddr  = curAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      remLen  <= '0;
      dirRead <= 1'b0;
    end else if (strobe.load) begin
      curAddr <= reqAddr;
      remLen  <= reqLen;
      dirRead <= reqRead;
    end else if (strobe.advance) begin
      curAddr <= curAddr + ADDR_W'(chunk);
      remLen  <= remLen - chunk;
    end
  end

  // R4: no descriptor ever exceeds one page
  assert_count_le_page_R4: assert property (@(posedge clk) disable iff (!rstN)
    descCount <= PAGE_LEN);

  // R3: after an accepted "more" chunk the next address is page aligned
  assert_more_ends_on_page_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !isLast) |=> (curAddr[PAGE_W-1:0] == '0));
endmodule

// File: rtl/dchain_top.sv
module dchain_top
  import dchain_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 24,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqRead,
  output logic              descValid,
  input  logic              descReady,
  output logic [2:0]        descCmd,
  output logic [LEN_W-1:0]  descCount,
  output logic [ADDR_W-1:0] descAddr,
  output logic [1:0]        descIntr,
  output logic [1:0]        descWait,
  output logic [1:0]        descBranch,
  output logic              chainDone
);
  dpStrobe_t strobe;
  logic      isLast;

  dchain_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .descReady(descReady),
    .isLast(isLast), .strobe(strobe), .reqReady(reqReady),
    .descValid(descValid), .chainDone(chainDone)
  );

  dchain_dp #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr), .reqLen(reqLen),
    .reqRead(reqRead), .isLast(isLast), .descCmd(descCmd),
    .descCount(descCount), .descAddr(descAddr)
  );

  assign descIntr   = CTL_NEVER;
  assign descWait   = CTL_NEVER;
  assign descBranch = CTL_NEVER;

  // R9: stalled descriptor holds its contents
  assert_hold_stalled_R9: assert property (@(posedge clk) disable iff (!rstN)
    (descValid && !descReady) |=> (descValid && $stable(descCmd) && $stable(descCount) && $stable(descAddr)));

  // R1: no request accepted while a descriptor is pending
  assert_idle_accept_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (descValid && !reqReady));

  // R7: stop descriptor carries zero count and address
  assert_stop_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (descValid && descCmd == 3'd7) |-> (descCount == '0 && descAddr == '0));
endmodule

// File: tb/tb_dchain_top.sv
module tb_dchain_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int LEN_W  = 16;
  localparam int PAGE   = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [LEN_W-1:0]  reqLen = '0;
  logic reqRead = 1'b0;
  logic descValid;
  logic descReady = 1'b0;
  logic [2:0] descCmd;
  logic [LEN_W-1:0] descCount;
  logic [ADDR_W-1:0] descAddr;
  logic [1:0] descIntr, descWait, descBranch;
  logic chainDone;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dchain_top #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqRead(reqRead),
    .descValid(descValid), .descReady(descReady), .descCmd(descCmd),
    .descCount(descCount), .descAddr(descAddr), .descIntr(descIntr),
    .descWait(descWait), .descBranch(descBranch), .chainDone(chainDone)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  int expN;
  int expCnt [16];
  int expAdr [16];
  int expCmd [16];

  // expected chain computed from the requirements (R2..R6, R10)
  task automatic buildExpected(input int addr, input int len, input bit rd);
    int a = addr;
    int l = len;
    int off = addr % PAGE;
    int more = rd ? 2 : 0;
    expN = 0;
    if (off != 0 && l > PAGE - off) begin
      expCnt[expN] = PAGE - off; expAdr[expN] = a; expCmd[expN] = more; expN++;
      a += PAGE - off; l -= PAGE - off;
    end
    while (l > PAGE) begin
      expCnt[expN] = PAGE; expAdr[expN] = a; expCmd[expN] = more; expN++;
      a += PAGE; l -= PAGE;
    end
    expCnt[expN] = l; expAdr[expN] = a; expCmd[expN] = more + 1; expN++;
  endtask

  task automatic runChain(input int addr, input int len, input bit rd,
                          input bit stall, input bit intrude, input string tag);
    int idx = 0;
    int cyc = 0;
    bit held = 0;
    logic [2:0] hCmd;
    logic [LEN_W-1:0] hCnt;
    logic [ADDR_W-1:0] hAdr;
    bit finished = 0;
    buildExpected(addr, len, rd);
    @(negedge clk);
    check(reqReady == 1'b1, {tag, " R1 idle ready"}, reqReady, 1);
    reqValid = 1'b1; reqAddr = ADDR_W'(addr); reqLen = LEN_W'(len); reqRead = rd;
    @(negedge clk);
    reqValid = 1'b0;
    while (!finished && cyc < 200) begin
      if (held) begin
        check(descCmd == hCmd && descCount == hCnt && descAddr == hAdr,
              {tag, " R9 hold"}, {descCmd, descCount, descAddr}, {hCmd, hCnt, hAdr});
        held = 0;
      end
      if (intrude && cyc == 1) begin
        check(reqReady == 1'b0, {tag, " R1 busy not ready"}, reqReady, 0);
        reqValid = 1'b1; reqAddr = 16'h7777; reqLen = 16'd5; reqRead = ~rd;
      end else begin
        reqValid = 1'b0;
      end
      descReady = stall ? (cyc % 3 != 0) : 1'b1;
      if (descValid) begin
        check(descIntr == 2'b00 && descWait == 2'b00 && descBranch == 2'b00,
              {tag, " R8 ctl never"}, {descIntr, descWait, descBranch}, 0);
        if (!descReady) begin
          held = 1; hCmd = descCmd; hCnt = descCount; hAdr = descAddr;
          check(chainDone == 1'b0, {tag, " R11 no done while stalled"}, chainDone, 0);
        end else if (idx < expN) begin
          check(descCmd == 3'(expCmd[idx]), {tag, " R6 cmd"}, descCmd, expCmd[idx]);
          check(descCount == LEN_W'(expCnt[idx]), {tag, " R2 R3 R4 R5 count"}, descCount, expCnt[idx]);
          check(descAddr == ADDR_W'(expAdr[idx]), {tag, " R3 addr"}, descAddr, expAdr[idx]);
          check(chainDone == 1'b0, {tag, " R11 no early done"}, chainDone, 0);
          idx++;
        end else begin
          check(descCmd == 3'd7 && descCount == '0 && descAddr == '0,
                {tag, " R7 stop"}, {descCmd, descCount, descAddr}, 7 << (LEN_W + ADDR_W));
          check(chainDone == 1'b1, {tag, " R11 done with stop"}, chainDone, 1);
          finished = 1;
        end
      end
      @(negedge clk);
      cyc++;
    end
    reqValid = 1'b0;
    descReady = 1'b0;
    check(finished, {tag, " R7 chain ended"}, finished, 1);
    check(chainDone == 1'b0 && reqReady == 1'b1, {tag, " R11 idle after done"},
          {chainDone, reqReady}, 1);
    check(descValid == 1'b0, {tag, " R1 no pending after done"}, descValid, 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(reqReady == 1'b1 && descValid == 1'b0 && chainDone == 1'b0,
          "reset R1", {reqReady, descValid, chainDone}, 3'b100);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    runChain(16'h0100, 200, 1'b0, 1'b0, 1'b0, "aligned multi R3 R4");
    runChain(16'h0130, 150, 1'b1, 1'b0, 1'b0, "unaligned span R2 R6");
    runChain(16'h0205,  40, 1'b0, 1'b0, 1'b0, "fits page R5");
    runChain(16'h0510,  48, 1'b1, 1'b0, 1'b0, "ends on boundary R5");
    runChain(16'h0400,  64, 1'b1, 1'b0, 1'b0, "exact page R4");
    runChain(16'h0620,   0, 1'b0, 1'b0, 1'b0, "zero len R10");
    runChain(16'h0333, 130, 1'b1, 1'b1, 1'b1, "stall intrude R9 R1");
    runChain(16'h0800, 129, 1'b0, 1'b1, 1'b0, "stall tail R9 R4");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule